// File: doc/BRIEF.md
# Sampled Operation Profiler

This block profiles a processor by picking single operations out of the stream of operations the core presents, rather than counting events in bulk. A reload counter counts presented operations and picks one when it runs out. The block then follows that one operation, by its tag, until the matching completion event arrives. It measures how many cycles the operation took, and it keeps the operation's program counter, its type, the data virtual address it touched and the outcome the completion reports.

For each finished sample the block writes a fixed four-word record, one 64-bit word per cycle, through a plain write port into a ring of word addresses bounded by a base and an inclusive limit. Software programs a watermark address. When the write pointer steps onto that address, an interrupt is raised and new picks are held off until software acknowledges. A pick that falls due while the block is still busy with an earlier sample is dropped and counted. An optional pseudo-random extension of the interval keeps the picks from locking onto loop periods.

Top module: `op_sampler`

## Requirements
- R1: While and after reset (enable low), mem_we is 0, irq is 0 and coll_count is 0.
- R2: With jitter off and enable high, each pick reloads the counter with N-1 (N = cfg_interval, 0 treated as 1), so exactly one of every N counted operations is picked. Deasserting enable also reloads N-1, so the N-th operation after enable rises is the first pick.
- R3: With cfg_jitter_en high, a pick reloads N-1 plus the low 3 bits of an 8-bit shift register. That register starts at 8'hA5 on reset, holds while jitter is off, and on each jittered reload shifts left, taking bit7^bit5^bit4^bit3 into bit 0.
- R4: A finished sample produces four writes on consecutive cycles at consecutive pointer positions: word 0 is the program counter, word 1 the completion virtual address, word 2 the latency in bits [15:0], and word 3 the outcome in bits [11:8] with the operation type in bits [7:0]. All other bits are zero.
- R5: The latency is the number of cycles from the cycle the operation is picked to the cycle its completion is seen, saturating at 65535. Outcome codes are recorded as given: 0 hit, 1 miss, 2 translation miss, 3 fault, 4 mispredict.
- R6: Completions whose tag differs from the tracked tag, and completions in the pick cycle itself, are ignored.
- R7: A pick that falls due while a sample is tracked or being written is dropped, and coll_count increments, saturating.
- R8: The pointer advances by one word per write and moves from cfg_limit back to cfg_base. A record may straddle the wrap.
- R9: When a write moves the pointer onto cfg_mark, irq rises and stays high until irq_ack. While irq is high, operations are not counted and nothing is picked. If a set and an acknowledge fall in the same cycle, the set wins.
- R10: Deasserting enable abandons any sample in progress, clears irq and returns the pointer to cfg_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Run sampling; low resets pointer, sample and counter |
| cfg_interval | input | IVL_W | Sampling interval N |
| cfg_jitter_en | input | 1 | Add pseudo-random extension to each reload |
| cfg_base | input | ADDR_W | First word address of the ring |
| cfg_limit | input | ADDR_W | Last word address of the ring (inclusive) |
| cfg_mark | input | ADDR_W | Pointer value that raises the interrupt |
| irq_ack | input | 1 | Clears the interrupt |
| op_valid | input | 1 | An operation is presented for counting |
| op_tag | input | TAG_W | Tag of the presented operation |
| op_pc | input | 64 | Program counter of the presented operation |
| op_type | input | 8 | Operation type code |
| cmp_valid | input | 1 | A completion event is presented |
| cmp_tag | input | TAG_W | Tag of the completing operation |
| cmp_va | input | 64 | Data virtual address of the completing operation |
| cmp_outcome | input | 4 | Outcome code of the completing operation |
| mem_we | output | 1 | Record word write strobe |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_wdata | output | 64 | Record word |
| irq | output | 1 | Watermark interrupt |
| coll_count | output | COLL_W | Number of dropped picks |

## Verification
A pick can fall due in the same cycle that the tracker is busy, either waiting on a completion or draining the four record words. Only the collision counter should move then, and neither the tracked sample nor the record should be disturbed. The bench provokes this by presenting operations on every cycle with an interval of one while the first pick is still waiting. It judges the result both from the final collision count and, on every cycle, against a behavioural model. That model also covers the interplay of the watermark interrupt with counting: operations presented while the interrupt is pending must neither be counted nor collide.

// File: rtl/op_sampler_pkg.sv
package op_sampler_pkg;

  localparam int WORD_W    = 64;
  localparam int REC_WORDS = 4;
  localparam int LAT_W     = 16;
  localparam int OUTC_W    = 4;
  localparam int OTYPE_W   = 8;
  localparam int LFSR_W    = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_WAIT = 2'd1,
    TRK_EMIT = 2'd2
  } trk_state_e;

  typedef enum logic [OUTC_W-1:0] {
    OUTC_HIT     = 4'd0,
    OUTC_MISS    = 4'd1,
    OUTC_XLMISS  = 4'd2,
    OUTC_FAULT   = 4'd3,
    OUTC_MISPRED = 4'd4
  } outcome_e;

  typedef struct packed {
    logic [WORD_W-1:0]  pc;
    logic [WORD_W-1:0]  va;
    logic [LAT_W-1:0]   lat;
    logic [OUTC_W-1:0]  outc;
    logic [OTYPE_W-1:0] otype;
  } sample_rec_t;

endpackage

// File: rtl/op_interval_gen.sv
// Counts presented operations and flags the one that is due for sampling.
module op_interval_gen
  import op_sampler_pkg::*;
#(
  parameter int IVL_W = 16,
  parameter int JIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             op_valid,
  input  logic             jitter_en,
  input  logic [IVL_W-1:0] interval,
  output logic             due
);

  localparam int CNT_W = IVL_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  reload_base, jit_add;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              cnt_ld, lfsr_ld, expire;

  always_comb begin
    reload_base = (interval == '0) ? '0 : ({1'b0, interval} - 1'b1);
    jit_add     = jitter_en ? {{(CNT_W-JIT_W){1'b0}}, lfsr_q[JIT_W-1:0]} : '0;
    expire      = (cnt_q == '0);
    due         = run && op_valid && expire;
    cnt_ld      = !en || (run && op_valid);
    lfsr_ld     = en && due && jitter_en;
    lfsr_d      = {lfsr_q[LFSR_W-2:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    if (!en)         cnt_d = reload_base;
    else if (expire) cnt_d = reload_base + jit_add;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lfsr_q <= LFSR_SEED;
    end else begin
      if (cnt_ld)  cnt_q  <= cnt_d;
      if (lfsr_ld) lfsr_q <= lfsr_d;
    end
  end

  // R3
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R2
  hold_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !run && $past(en) |=> $stable(cnt_q));

endmodule

// File: rtl/op_sample_track.sv
// Follows one picked operation until its completion and holds its record.
module op_sample_track
  import op_sampler_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int COLL_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                due,
  input  logic [TAG_W-1:0]    op_tag,
  input  logic [WORD_W-1:0]   op_pc,
  input  logic [OTYPE_W-1:0]  op_type,
  input  logic                cmp_valid,
  input  logic [TAG_W-1:0]    cmp_tag,
  input  logic [WORD_W-1:0]   cmp_va,
  input  logic [OUTC_W-1:0]   cmp_outcome,
  input  logic                emit_done,
  output logic                emit,
  output sample_rec_t         rec,
  output logic [COLL_W-1:0]   coll_count
);

  trk_state_e        st_q, st_d;
  logic [TAG_W-1:0]  tag_q;
  logic [WORD_W-1:0] pc_q, va_q;
  logic [OTYPE_W-1:0] typ_q;
  logic [OUTC_W-1:0] outc_q;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic [COLL_W-1:0] coll_q;
  logic              busy, take, hit, lat_ld, coll_ld;

  always_comb begin
    busy    = (st_q != TRK_IDLE);
    take    = due && !busy;
    hit     = (st_q == TRK_WAIT) && cmp_valid && (cmp_tag == tag_q);
    lat_ld  = take || (st_q == TRK_WAIT);
    lat_d   = take ? '0 : ((lat_q == '1) ? lat_q : lat_q + 1'b1);
    coll_ld = due && busy && (coll_q != '1);
    st_d    = st_q;
    if (!en) begin
      st_d = TRK_IDLE;
    end else begin
      unique case (st_q)
        TRK_IDLE: if (take)      st_d = TRK_WAIT;
        TRK_WAIT: if (hit)       st_d = TRK_EMIT;
        TRK_EMIT: if (emit_done) st_d = TRK_IDLE;
        default:                 st_d = TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_IDLE;
      tag_q  <= '0;
      pc_q   <= '0;
      typ_q  <= '0;
      va_q   <= '0;
      outc_q <= '0;
      lat_q  <= '0;
      coll_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        tag_q <= op_tag;
        pc_q  <= op_pc;
        typ_q <= op_type;
      end
      if (hit) begin
        va_q   <= cmp_va;
        outc_q <= cmp_outcome;
      end
      if (lat_ld)  lat_q  <= lat_d;
      if (coll_ld) coll_q <= coll_q + 1'b1;
    end
  end

  assign emit       = (st_q == TRK_EMIT);
  assign coll_count = coll_q;
  assign rec        = '{pc: pc_q, va: va_q, lat: lat_q, outc: outc_q, otype: typ_q};

  // R5
  lat_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_WAIT) && $past(st_q == TRK_WAIT) |-> lat_q >= $past(lat_q));

  // R7
  coll_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_q >= $past(coll_q));

endmodule

// File: rtl/op_ring_writer.sv
// Streams the held record into the ring and runs the watermark interrupt.
module op_ring_writer
  import op_sampler_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              emit,
  input  sample_rec_t       rec,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] mark,
  input  logic              ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              irq,
  output logic              emit_done
);

  localparam int BEAT_W = $clog2(REC_WORDS);

  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_step;
  logic              irq_q, irq_d, ptr_ld;
  logic [WORD_W-1:0] words [REC_WORDS];

  always_comb begin
    words[0] = rec.pc;
    words[1] = rec.va;
    words[2] = {{(WORD_W-LAT_W){1'b0}}, rec.lat};
    words[3] = {{(WORD_W-OUTC_W-OTYPE_W){1'b0}}, rec.outc, rec.otype};
  end

  always_comb begin
    ptr_step  = (ptr_q == limit) ? base : ptr_q + 1'b1;
    emit_done = emit && (beat_q == BEAT_W'(REC_WORDS-1));
    ptr_ld    = !en || emit;
    ptr_d     = en ? ptr_step : base;
    beat_d    = (en && emit) ? beat_q + 1'b1 : '0;
    if (!en)                          irq_d = 1'b0;
    else if (emit && ptr_step == mark) irq_d = 1'b1;
    else if (ack)                     irq_d = 1'b0;
    else                              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      ptr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      beat_q <= beat_d;
      if (ptr_ld) ptr_q <= ptr_d;
      irq_q <= irq_d;
    end
  end

  assign mem_we    = emit;
  assign mem_addr  = ptr_q;
  assign mem_wdata = words[beat_q];
  assign irq       = irq_q;

  // R4
  rec_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) && en |=> mem_we);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack && en |=> irq);

endmodule

// File: rtl/op_sampler.sv
// Sampled operation profiler top. rst_n is expected to be deasserted
// synchronously to clk by the reset tree.
module op_sampler
  import op_sampler_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 6,
  parameter int IVL_W  = 16,
  parameter int JIT_W  = 3,
  parameter int COLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic              cfg_jitter_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic [ADDR_W-1:0] cfg_mark,
  input  logic              irq_ack,
  input  logic              op_valid,
  input  logic [TAG_W-1:0]  op_tag,
  input  logic [63:0]       op_pc,
  input  logic [7:0]        op_type,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [63:0]       cmp_va,
  input  logic [3:0]        cmp_outcome,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic              irq,
  output logic [COLL_W-1:0] coll_count
);

  logic        run, due, emit, emit_done, irq_w;
  sample_rec_t rec;

  assign run = cfg_enable && !irq_w;
  assign irq = irq_w;

  op_interval_gen #(.IVL_W(IVL_W), .JIT_W(JIT_W)) u_ivl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_enable),
    .run       (run),
    .op_valid  (op_valid),
    .jitter_en (cfg_jitter_en),
    .interval  (cfg_interval),
    .due       (due)
  );

  op_sample_track #(.TAG_W(TAG_W), .COLL_W(COLL_W)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cfg_enable),
    .due         (due),
    .op_tag      (op_tag),
    .op_pc       (op_pc),
    .op_type     (op_type),
    .cmp_valid   (cmp_valid),
    .cmp_tag     (cmp_tag),
    .cmp_va      (cmp_va),
    .cmp_outcome (cmp_outcome),
    .emit_done   (emit_done),
    .emit        (emit),
    .rec         (rec),
    .coll_count  (coll_count)
  );

  op_ring_writer #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_enable),
    .emit      (emit),
    .rec       (rec),
    .base      (cfg_base),
    .limit     (cfg_limit),
    .mark      (cfg_mark),
    .ack       (irq_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq       (irq_w),
    .emit_done (emit_done)
  );

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !mem_we && !irq);

endmodule

// File: tb/op_sampler_tb_top.sv
module op_sampler_tb_top;
  localparam int ADDR_W = 16;
  localparam int TAG_W  = 6;
  localparam int IVL_W  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, cfg_enable, cfg_jitter_en, irq_ack;
  logic [IVL_W-1:0]  cfg_interval;
  logic [ADDR_W-1:0] cfg_base, cfg_limit, cfg_mark;
  logic              op_valid, cmp_valid;
  logic [TAG_W-1:0]  op_tag, cmp_tag;
  logic [63:0]       op_pc, cmp_va;
  logic [7:0]        op_type;
  logic [3:0]        cmp_outcome;
  logic              mem_we, irq;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0]       mem_wdata;
  logic [15:0]       coll_count;

  op_sampler #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .IVL_W(IVL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_interval(cfg_interval),
    .cfg_jitter_en(cfg_jitter_en), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_mark(cfg_mark), .irq_ack(irq_ack), .op_valid(op_valid), .op_tag(op_tag),
    .op_pc(op_pc), .op_type(op_type), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_va(cmp_va), .cmp_outcome(cmp_outcome), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq), .coll_count(coll_count)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit running = 1'b0;
  int nwr = 0;
  logic [63:0] bmem [256];

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] lf_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [63:0] w3(input logic [3:0] o, input logic [7:0] t);
    return {52'd0, o, t};
  endfunction

  // Behavioural reference model, advanced at each rising edge.
  int          m_cnt, m_st, m_lat, m_beat, m_coll;
  logic [7:0]  m_lf, m_typ;
  logic [5:0]  m_tag;
  logic [63:0] m_pc, m_va;
  logic [3:0]  m_out;
  logic [15:0] m_ptr;
  bit          m_irq;

  task automatic model_step();
    bit run, due, busy, we, hit;
    int rl, n_cnt, n_st, n_lat, n_beat;
    logic [7:0] n_lf;
    logic [15:0] nx, n_ptr;
    bit n_irq;
    rl = (cfg_interval == 0) ? 0 : int'(cfg_interval) - 1;
    run = cfg_enable && !m_irq;
    due = run && op_valid && (m_cnt == 0);
    busy = (m_st != 0);
    we = (m_st == 2);
    hit = (m_st == 1) && cmp_valid && (cmp_tag == m_tag);
    n_cnt = m_cnt; n_lf = m_lf; n_st = m_st; n_lat = m_lat; n_beat = 0;
    n_ptr = m_ptr; n_irq = m_irq;
    if (!cfg_enable) n_cnt = rl;
    else if (run && op_valid) begin
      if (m_cnt == 0) begin
        n_cnt = rl + (cfg_jitter_en ? int'(m_lf[2:0]) : 0);
        if (cfg_jitter_en) n_lf = lf_next(m_lf);
      end else n_cnt = m_cnt - 1;
    end
    if (due && busy && m_coll < 65535) m_coll++;
    if (!cfg_enable) n_st = 0;
    else if (m_st == 0 && due) begin
      n_st = 1; m_tag = op_tag; m_pc = op_pc; m_typ = op_type; n_lat = 0;
    end else if (m_st == 1) begin
      n_lat = (m_lat < 65535) ? m_lat + 1 : 65535;
      if (hit) begin n_st = 2; m_va = cmp_va; m_out = cmp_outcome; end
    end else if (m_st == 2 && m_beat == 3) n_st = 0;
    if (!cfg_enable) begin n_ptr = cfg_base; n_irq = 0; end
    else begin
      nx = (m_ptr == cfg_limit) ? cfg_base : m_ptr + 16'd1;
      if (we) begin n_ptr = nx; n_beat = (m_beat + 1) % 4; end
      if (we && nx == cfg_mark) n_irq = 1;
      else if (irq_ack) n_irq = 0;
    end
    m_cnt = n_cnt; m_lf = n_lf; m_st = n_st; m_lat = n_lat; m_beat = n_beat;
    m_ptr = n_ptr; m_irq = n_irq;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lf = 8'hA5; m_st = 0; m_lat = 0; m_beat = 0; m_coll = 0;
      m_ptr = 0; m_irq = 0; m_tag = 0; m_pc = 0; m_va = 0; m_typ = 0; m_out = 0;
    end else model_step();
  end

  // Per-cycle comparison and write capture, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && running) begin
      check("R8", "mem_we", {63'd0, mem_we}, {63'd0, m_st == 2});
      if (m_st == 2) begin
        check("R8", "mem_addr", {48'd0, mem_addr}, {48'd0, m_ptr});
        case (m_beat)
          0: check("R4", "word0 pc", mem_wdata, m_pc);
          1: check("R4", "word1 va", mem_wdata, m_va);
          2: check("R5", "word2 latency", mem_wdata, 64'(m_lat));
          default: check("R4", "word3 outcome/type", mem_wdata, w3(m_out, m_typ));
        endcase
      end
      check("R9", "irq", {63'd0, irq}, {63'd0, m_irq});
      check("R7", "coll_count", {48'd0, coll_count}, 64'(m_coll));
    end
    if (rst_n && mem_we) begin
      bmem[mem_addr[7:0]] = mem_wdata;
      nwr++;
    end
  end

  task automatic drive(input bit ov, input int tag, input logic [63:0] pc, input int typ,
                       input bit cv, input int ctag, input logic [63:0] va, input int oc);
    @(negedge clk);
    op_valid = ov; op_tag = TAG_W'(tag); op_pc = pc; op_type = 8'(typ);
    cmp_valid = cv; cmp_tag = TAG_W'(ctag); cmp_va = va; cmp_outcome = 4'(oc);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 64'd0, 0, 0, 0, 64'd0, 0);
  endtask

  function automatic logic [63:0] pcf(input int i);
    return 64'h4000_0000_0000_1000 + 64'(i) * 4;
  endfunction

  function automatic logic [63:0] vaf(input int i);
    return 64'h7fff_0000_0000_0000 + 64'(i) * 64;
  endfunction

  // Presents op i and its completion one or two cycles later, then idles.
  task automatic op_and_done(input int i, input int gap);
    drive(1, i, pcf(i), i, 0, 0, 64'd0, 0);
    if (gap == 2) idle(1);
    drive(0, 0, 64'd0, 0, 1, i, vaf(i), i % 5);
    idle(6);
  endtask

  task automatic reconfig(input int n, input bit jit, input int b, input int l, input int mk);
    @(negedge clk);
    cfg_enable = 0; cfg_interval = 16'(n); cfg_jitter_en = jit;
    cfg_base = 16'(b); cfg_limit = 16'(l); cfg_mark = 16'(mk);
    idle(1);
    cfg_enable = 1;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    int snap, cs, nsel, cnt;
    logic [7:0] lf;
    int sel [$];
    rst_n = 0; cfg_enable = 0; cfg_jitter_en = 0; irq_ack = 0; cfg_interval = 1;
    cfg_base = 0; cfg_limit = 0; cfg_mark = 0;
    op_valid = 0; cmp_valid = 0; op_tag = 0; cmp_tag = 0; op_pc = 0; cmp_va = 0;
    op_type = 0; cmp_outcome = 0;
    repeat (4) @(negedge clk);
    check("R1", "mem_we in reset", {63'd0, mem_we}, 64'd0);
    check("R1", "irq in reset", {63'd0, irq}, 64'd0);
    check("R1", "coll in reset", {48'd0, coll_count}, 64'd0);
    rst_n = 1;
    running = 1;
    idle(2);
    check("R1", "mem_we after reset", {63'd0, mem_we}, 64'd0);
    check("R1", "coll after reset", {48'd0, coll_count}, 64'd0);

    // R2 / R4 / R5: interval 3, picks are ops 2,5,8,11, latency 2
    reconfig(3, 0, 16, 63, 0);
    for (int i = 0; i < 12; i++) op_and_done(i, 2);
    idle(10);
    check("R2", "records written interval 3", 64'(nwr), 64'd16);
    for (int k = 0; k < 4; k++) begin
      check("R2", "picked pc", bmem[16 + 4*k], pcf(3*k + 2));
      check("R4", "va word", bmem[17 + 4*k], vaf(3*k + 2));
      check("R5", "latency word", bmem[18 + 4*k], 64'd2);
      check("R4", "outcome/type word", bmem[19 + 4*k], w3(4'((3*k + 2) % 5), 8'(3*k + 2)));
    end

    // R10: abandon on disable, pointer back to base
    reconfig(1, 0, 16, 63, 0);
    drive(1, 7, pcf(50), 50, 0, 0, 64'd0, 0);
    idle(1);
    cfg_enable = 0;
    idle(1);
    cfg_enable = 1;
    snap = nwr;
    drive(0, 0, 64'd0, 0, 1, 7, vaf(50), 1);
    idle(8);
    check("R10", "abandoned sample writes nothing", 64'(nwr), 64'(snap));
    // R6: wrong tag ignored, latency counts to the matching completion
    drive(1, 5, pcf(60), 60, 0, 0, 64'd0, 0);
    drive(0, 0, 64'd0, 0, 1, 6, vaf(99), 3);
    idle(2);
    drive(0, 0, 64'd0, 0, 1, 5, vaf(60), 4);
    idle(8);
    check("R10", "record at base after re-enable", bmem[16], pcf(60));
    check("R6", "latency ignores wrong tag", bmem[18], 64'd4);
    check("R6", "va from matching completion", bmem[17], vaf(60));

    // R7: back-to-back picks while tracking
    for (int i = 0; i < 20; i++) drive(1, 20 + i, pcf(100 + i), 1, 0, 0, 64'd0, 0);
    drive(0, 0, 64'd0, 0, 1, 20, vaf(100), 0);
    idle(8);
    check("R7", "collisions counted", {48'd0, coll_count}, 64'd19);
    check("R7", "tracked sample kept", bmem[20], pcf(100));

    // R8: wrap inside a 6-word ring
    reconfig(1, 0, 40, 45, 0);
    for (int k = 0; k < 3; k++) op_and_done(200 + k, 1);
    idle(4);
    check("R8", "rec1 word3 after wrap", bmem[41], w3(4'((201) % 5), 8'(201)));
    check("R8", "rec1 latency after wrap", bmem[40], 64'd1);
    check("R8", "rec2 pc", bmem[42], pcf(202));
    check("R8", "rec2 va", bmem[43], vaf(202));

    // R9: watermark interrupt pauses picking
    reconfig(1, 0, 40, 63, 48);
    op_and_done(300, 1);
    op_and_done(301, 1);
    idle(2);
    check("R9", "irq raised at mark", {63'd0, irq}, 64'd1);
    snap = nwr; cs = coll_count;
    for (int k = 0; k < 3; k++) op_and_done(310 + k, 1);
    check("R9", "no record while paused", 64'(nwr), 64'(snap));
    check("R9", "no collision while paused", {48'd0, coll_count}, 64'(cs));
    check("R9", "irq held", {63'd0, irq}, 64'd1);
    irq_ack = 1;
    idle(1);
    irq_ack = 0;
    idle(1);
    check("R9", "irq cleared by ack", {63'd0, irq}, 64'd0);
    op_and_done(320, 1);
    idle(2);
    check("R9", "picking resumes at mark", bmem[48], pcf(320));

    // R3: jittered interval 2
    reconfig(2, 1, 0, 255, 200);
    snap = nwr;
    for (int i = 0; i < 24; i++) op_and_done(400 + i, 1);
    idle(6);
    cnt = 1; lf = 8'hA5;
    for (int i = 0; i < 24; i++) begin
      if (cnt == 0) begin
        sel.push_back(400 + i);
        cnt = 1 + int'(lf[2:0]);
        lf = lf_next(lf);
      end else cnt--;
    end
    nsel = sel.size();
    check("R3", "jittered record count", 64'(nwr - snap), 64'(4 * nsel));
    for (int k = 0; k < nsel; k++) check("R3", "jittered pick pc", bmem[4*k], pcf(sel[k]));

    finished = 1;
    summary();
    $finish;
  end

endmodule